// File: doc/BRIEF.md
# Interrupt Status Register with Polarity-Controlled Pin

This block holds the interrupt status word of a memory controller. It keeps one master interrupt bit and four per-source pending bits, one each for read (load) completion, write completion, erase completion and reset completion. The controller raises a single-cycle strobe for each completed operation, which sets the matching pending bit. The host reads the word over a simple register bus. It acknowledges sources by writing zero to their bits, and when automatic mode is on, the next command write clears every bit at once. The master bit drives an external interrupt pin through a polarity control, so the pin can be active high or active low.

The master bit is a two-state machine. State `MST_IDLE` means the master bit is 0 and `MST_PENDING` means it is 1. There are three transitions. `T_RAISE` goes from `MST_IDLE` to `MST_PENDING` when any pending bit will be 1 after the edge. `T_ACK` goes from `MST_PENDING` to `MST_IDLE` when the master bit is cleared by a host zero-write or an automatic clear, and no pending bit will be 1 after the edge. `T_RESET` enters `MST_PENDING` from either state whenever reset is asserted. In every other case the state holds.

Reset is synchronous. A reset-type input selects which default word is loaded, so a cold start and a warm or hot restart each report their own completion source. When two dies share the bus, host writes take effect only while the die-select flag is set.

Top module: `irq_status_reg`

## Requirements
- R1: The word places the master bit at bit 15, the read pending bit at bit 7, the write pending bit at bit 6, the erase pending bit at bit 5 and the reset pending bit at bit 4. All other bits always read 0.
- R2: A clock edge with `rst` high loads 0x8080 when `rst_warm` is 0 (cold) and 0x8010 when `rst_warm` is 1 (warm or hot).
- R3: A one-cycle strobe on `ev_read`, `ev_write`, `ev_erase` or `ev_reset` sets its pending bit and the master bit at the same clock edge.
- R4: An accepted bus write at word address 0xF241 clears every pending bit whose write-data bit is 0. Write-data bits that are 1 leave their bits unchanged.
- R5: A write to any address other than 0xF241 changes nothing. `bus_rdata` returns the status word when `bus_addr` is 0xF241 and returns 0 otherwise.
- R6: The master bit is 1 whenever any pending bit is 1. It falls to 0 only when it is cleared (by writing 0 to bit 15 or by an automatic clear) and no pending bit remains set.
- R7: With `auto_mode` high, a `cmd_wr` strobe clears the master bit and all pending bits. With `auto_mode` low, `cmd_wr` has no effect.
- R8: When a completion strobe and a clear (host zero-write or automatic clear) hit the same bit at the same edge, the strobe wins and the bit ends up 1.
- R9: `irq_pin` equals the master bit when `pin_pol` is 1 and its inverse when `pin_pol` is 0. The pin follows the master bit with no extra delay.
- R10: While `dual_die` is 1, host writes are ignored unless `die_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_warm | input | 1 | Reset type: 0 cold, 1 warm/hot |
| bus_addr | input | 16 | Register bus word address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 16 | Register bus write data |
| bus_rdata | output | 16 | Register bus read data |
| ev_read | input | 1 | Load/boot completion strobe |
| ev_write | input | 1 | Program completion strobe |
| ev_erase | input | 1 | Erase completion strobe |
| ev_reset | input | 1 | Reset completion strobe |
| cmd_wr | input | 1 | Command register written strobe |
| auto_mode | input | 1 | Enables clear-on-command |
| pin_pol | input | 1 | Interrupt pin polarity (1 = active high) |
| dual_die | input | 1 | Two-die configuration flag |
| die_sel | input | 1 | Die-select flag gating host writes |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The assertions assume every input is stable across the clock edge and that each completion strobe lasts one cycle. They also assume reset is held for at least one edge before status is judged. Because the stability and clear checks are written over the previous cycle, they are conditioned on no strobe arriving in the checked cycle. The bench drives every input one time unit after the rising edge and returns all strobes to 0 at the next edge. Reset is applied only as whole cycles, so the stimulus meets these assumptions. The randomized phase mixes strobes, zero-writes, command writes and changes of polarity and die select in the same cycles, which exercises the precedence rules.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int STAT_W     = 16;
    localparam int SRC_N      = 4;
    localparam int MST_POS    = 15;
    localparam int SRC_TOP    = 7;

    localparam logic [STAT_W-1:0] COLD_WORD = 16'h8080;
    localparam logic [STAT_W-1:0] WARM_WORD = 16'h8010;

    // Source index to bit position: read 7, write 6, erase 5, reset 4.
    typedef enum logic [1:0] {
        SRC_RD = 2'd0,
        SRC_WR = 2'd1,
        SRC_ER = 2'd2,
        SRC_RS = 2'd3
    } src_e;

    typedef enum logic {
        MST_IDLE    = 1'b0,
        MST_PENDING = 1'b1
    } mst_state_e;

    function automatic int src_pos(input int idx);
        return SRC_TOP - idx;
    endfunction

endpackage

// File: rtl/irq_bus_dec.sv
module irq_bus_dec
    import irq_stat_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hF241
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [STAT_W-1:0] bus_wdata,
    input  logic              dual_die,
    input  logic              die_sel,
    input  logic              cmd_wr,
    input  logic              auto_mode,
    output logic              addr_hit,
    output logic [SRC_N-1:0]  src_clr,
    output logic              mst_clr
);

    logic wr_ok;
    logic auto_clr;

    always_comb begin
        addr_hit = (bus_addr == REG_ADDR);
        wr_ok    = bus_we && addr_hit && (!dual_die || die_sel);
        auto_clr = cmd_wr && auto_mode;
        mst_clr  = auto_clr || (wr_ok && !bus_wdata[MST_POS]);
    end

    for (genvar gi = 0; gi < SRC_N; gi++) begin : g_clr
        localparam int POS = src_pos(gi);
        assign src_clr[gi] = auto_clr || (wr_ok && !bus_wdata[POS]);
    end

endmodule

// File: rtl/irq_src_bit.sv
module irq_src_bit #(
    parameter logic DEF_COLD = 1'b0,
    parameter logic DEF_WARM = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_warm,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o,
    output logic nxt_o
);

    always_comb begin
        if (rst) begin
            nxt_o = rst_warm ? DEF_WARM : DEF_COLD;
        end else if (set_i) begin
            nxt_o = 1'b1;
        end else if (clr_i) begin
            nxt_o = 1'b0;
        end else begin
            nxt_o = q_o;
        end
    end

    always_ff @(posedge clk) begin
        q_o <= nxt_o;
    end

endmodule

// File: rtl/irq_master_fsm.sv
module irq_master_fsm
    import irq_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       any_src_next,
    input  logic       clr_i,
    output mst_state_e state_o,
    output logic       master_o
);

    mst_state_e state_q;
    mst_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MST_IDLE: begin
                if (any_src_next) state_d = MST_PENDING;      // T_RAISE
            end
            MST_PENDING: begin
                if (clr_i && !any_src_next) state_d = MST_IDLE; // T_ACK
            end
            default: state_d = MST_PENDING;
        endcase
        if (rst) state_d = MST_PENDING;                      // T_RESET
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        state_o = state_q;
        unique case (state_q)
            MST_IDLE:    master_o = 1'b0;
            MST_PENDING: master_o = 1'b1;
            default:     master_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_stat_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hF241
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_warm,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    input  logic              ev_read,
    input  logic              ev_write,
    input  logic              ev_erase,
    input  logic              ev_reset,
    input  logic              cmd_wr,
    input  logic              auto_mode,
    input  logic              pin_pol,
    input  logic              dual_die,
    input  logic              die_sel,
    output logic              irq_pin
);

    logic [SRC_N-1:0]  src_set;
    logic [SRC_N-1:0]  src_clr;
    logic [SRC_N-1:0]  src_q;
    logic [SRC_N-1:0]  src_nxt;
    logic              mst_clr;
    logic              addr_hit;
    logic              master;
    mst_state_e        mst_state;
    logic [STAT_W-1:0] stat_q;

    always_comb begin
        src_set         = '0;
        src_set[SRC_RD] = ev_read;
        src_set[SRC_WR] = ev_write;
        src_set[SRC_ER] = ev_erase;
        src_set[SRC_RS] = ev_reset;
    end

    irq_bus_dec #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_dec (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .dual_die  (dual_die),
        .die_sel   (die_sel),
        .cmd_wr    (cmd_wr),
        .auto_mode (auto_mode),
        .addr_hit  (addr_hit),
        .src_clr   (src_clr),
        .mst_clr   (mst_clr)
    );

    for (genvar gi = 0; gi < SRC_N; gi++) begin : g_src
        localparam int   POS = src_pos(gi);
        localparam logic DC  = COLD_WORD[POS];
        localparam logic DW  = WARM_WORD[POS];
        irq_src_bit #(
            .DEF_COLD (DC),
            .DEF_WARM (DW)
        ) u_bit (
            .clk      (clk),
            .rst      (rst),
            .rst_warm (rst_warm),
            .set_i    (src_set[gi]),
            .clr_i    (src_clr[gi]),
            .q_o      (src_q[gi]),
            .nxt_o    (src_nxt[gi])
        );
    end

    irq_master_fsm u_mst (
        .clk          (clk),
        .rst          (rst),
        .any_src_next (|src_nxt),
        .clr_i        (mst_clr),
        .state_o      (mst_state),
        .master_o     (master)
    );

    always_comb begin
        stat_q          = '0;
        stat_q[MST_POS] = master;
        for (int i = 0; i < SRC_N; i++) begin
            stat_q[src_pos(i)] = src_q[i];
        end
    end

    assign bus_rdata = addr_hit ? stat_q : '0;
    assign irq_pin   = pin_pol ? master : ~master;

endmodule

// File: rtl/irq_status_reg_chk.sv
module irq_status_reg_chk
    import irq_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rst_warm,
    input logic [STAT_W-1:0] stat_q,
    input logic              ev_read,
    input logic              ev_write,
    input logic              ev_erase,
    input logic              ev_reset,
    input logic              cmd_wr,
    input logic              auto_mode,
    input logic              bus_we,
    input logic              dual_die,
    input logic              die_sel,
    input logic              pin_pol,
    input logic              irq_pin
);

    logic prev_rst  = 1'b0;
    logic prev_warm = 1'b0;
    logic any_ev;

    assign any_ev = ev_read || ev_write || ev_erase || ev_reset;

    always_ff @(posedge clk) begin
        prev_rst  <= rst;
        prev_warm <= rst_warm;
    end

    // R2: default word after a reset edge
    always @(negedge clk) begin
        if (prev_rst) begin
            a_r2_reset_word: assert (stat_q == (prev_warm ? WARM_WORD : COLD_WORD))
                else $error("reset word wrong");
        end
    end

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (stat_q & 16'h7F0F) == 16'h0);

    a_r3_read_sets: assert property (@(posedge clk) disable iff (rst)
        ev_read |=> (stat_q[7] && stat_q[15]));

    a_r8_write_beats_clear: assert property (@(posedge clk) disable iff (rst)
        ev_write |=> stat_q[6]);

    a_r6_master_follows: assert property (@(posedge clk) disable iff (rst)
        (|stat_q[7:4]) |-> stat_q[15]);

    a_r7_auto_clear: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && auto_mode && !any_ev) |=> (stat_q == 16'h0));

    a_r10_die_gate: assert property (@(posedge clk) disable iff (rst)
        (bus_we && dual_die && !die_sel && !any_ev && !(cmd_wr && auto_mode))
            |=> $stable(stat_q));

    a_r9_pin_idle_level: assert property (@(posedge clk) disable iff (rst)
        !stat_q[15] |-> (irq_pin == !pin_pol));

endmodule

bind irq_status_reg irq_status_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rst_warm  (rst_warm),
    .stat_q    (stat_q),
    .ev_read   (ev_read),
    .ev_write  (ev_write),
    .ev_erase  (ev_erase),
    .ev_reset  (ev_reset),
    .cmd_wr    (cmd_wr),
    .auto_mode (auto_mode),
    .bus_we    (bus_we),
    .dual_die  (dual_die),
    .die_sel   (die_sel),
    .pin_pol   (pin_pol),
    .irq_pin   (irq_pin)
);

// File: tb/irq_status_reg_tb_top.sv
module irq_status_reg_tb_top;

    localparam logic [15:0] ADDR = 16'hF241;

    logic        clk = 1'b0;
    logic        rst = 1'b0, rst_warm = 1'b0;
    logic [15:0] bus_addr = ADDR;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        ev_read = 0, ev_write = 0, ev_erase = 0, ev_reset = 0;
    logic        cmd_wr = 0, auto_mode = 1, pin_pol = 1;
    logic        dual_die = 0, die_sel = 0;
    logic        irq_pin;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R2";
    logic [15:0] m = 16'h0;

    always #4 clk = ~clk;

    irq_status_reg dut_i (
        .clk(clk), .rst(rst), .rst_warm(rst_warm),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ev_read(ev_read), .ev_write(ev_write), .ev_erase(ev_erase),
        .ev_reset(ev_reset), .cmd_wr(cmd_wr), .auto_mode(auto_mode),
        .pin_pol(pin_pol), .dual_die(dual_die), .die_sel(die_sel),
        .irq_pin(irq_pin)
    );

    function automatic void chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m = rst_warm ? 16'h8010 : 16'h8080;
        end else begin
            bit wr_ok, autoc, anyp;
            bit evs[4];
            int pos;
            wr_ok  = bus_we && bus_addr == ADDR && (!dual_die || die_sel);
            autoc  = cmd_wr && auto_mode;
            evs[0] = ev_read; evs[1] = ev_write; evs[2] = ev_erase; evs[3] = ev_reset;
            for (int k = 0; k < 4; k++) begin
                pos = 7 - k;
                if (evs[k]) m[pos] = 1'b1;
                else if (autoc || (wr_ok && !bus_wdata[pos])) m[pos] = 1'b0;
            end
            anyp = (m[7:4] != 4'h0);
            if (anyp) m[15] = 1'b1;
            else if (autoc || (wr_ok && !bus_wdata[15])) m[15] = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, bus_rdata, (bus_addr == ADDR) ? m : 16'h0);
            chk("R9", {15'h0, irq_pin}, {15'h0, pin_pol ? m[15] : ~m[15]});
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        rst = 0; bus_we = 0; cmd_wr = 0;
        ev_read = 0; ev_write = 0; ev_erase = 0; ev_reset = 0;
    endtask

    task automatic expect_word(string req, logic [15:0] exp);
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic host_write(logic [15:0] d);
        bus_we = 1; bus_wdata = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        // R2 cold
        rst = 1; rst_warm = 0; tick(); started = 1;
        expect_word("R2", 16'h8080);
        chk("R9", {15'h0, irq_pin}, 16'h1);
        rst = 1; rst_warm = 1; tick();
        expect_word("R2", 16'h8010);
        cur_req = "R4";
        host_write(16'hFFFF); tick(); expect_word("R4", 16'h8010);
        cur_req = "R6";
        host_write(16'h8000); tick(); expect_word("R6", 16'h8000);
        host_write(16'h0000); tick(); expect_word("R6", 16'h0000);
        chk("R9", {15'h0, irq_pin}, 16'h0);
        cur_req = "R3";
        ev_read = 1;  tick(); expect_word("R3", 16'h8080);
        ev_write = 1; tick(); expect_word("R3", 16'h80C0);
        ev_erase = 1; tick(); expect_word("R3", 16'h80E0);
        ev_reset = 1; tick(); expect_word("R1", 16'h80F0);
        cur_req = "R6";
        host_write(16'h7FFF); tick(); expect_word("R6", 16'h80F0);
        cur_req = "R5";
        bus_addr = 16'hF240; host_write(16'h0000); tick();
        expect_word("R5", 16'h0000);
        bus_addr = ADDR; expect_word("R5", 16'h80F0);
        cur_req = "R8";
        host_write(16'hFF7F); ev_read = 1; tick(); expect_word("R8", 16'h80F0);
        cur_req = "R4";
        host_write(16'hFFBF); tick(); expect_word("R4", 16'h80B0);
        cur_req = "R7";
        auto_mode = 0; cmd_wr = 1; tick(); expect_word("R7", 16'h80B0);
        auto_mode = 1; cmd_wr = 1; ev_erase = 1; tick(); expect_word("R8", 16'h8020);
        cmd_wr = 1; tick(); expect_word("R7", 16'h0000);
        cur_req = "R9";
        pin_pol = 0; #1; chk("R9", {15'h0, irq_pin}, 16'h1);
        ev_write = 1; tick(); expect_word("R3", 16'h8040);
        chk("R9", {15'h0, irq_pin}, 16'h0);
        cur_req = "R10";
        dual_die = 1; die_sel = 0; host_write(16'h0000); tick();
        expect_word("R10", 16'h8040);
        die_sel = 1; host_write(16'h0000); tick(); expect_word("R10", 16'h0000);

        // Mixed random phase
        cur_req = "R1";
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = $urandom_range(0, 99);
            ev_read  = ($urandom_range(0, 9) == 0);
            ev_write = ($urandom_range(0, 9) == 0);
            ev_erase = ($urandom_range(0, 9) == 0);
            ev_reset = ($urandom_range(0, 9) == 0);
            cmd_wr   = ($urandom_range(0, 7) == 0);
            auto_mode = ($urandom_range(0, 3) != 0);
            bus_we   = ($urandom_range(0, 2) == 0);
            bus_wdata = 16'($urandom);
            bus_addr = ($urandom_range(0, 5) == 0) ? 16'($urandom) : ADDR;
            dual_die = ($urandom_range(0, 1) == 0);
            die_sel  = ($urandom_range(0, 1) == 0);
            if (r < 10) pin_pol = ~pin_pol;
            if (r == 99) begin rst = 1; rst_warm = $urandom_range(0, 1); end
            tick();
        end
        bus_addr = ADDR;
        @(negedge clk); #1;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule